// File: doc/BRIEF.md
# Compressor-Tree Unsigned Multiplier

This block multiplies two unsigned operands in a single pass of combinational logic and returns the full double-width product. It forms one shifted row per multiplier bit, flattens those rows to two using carry-save compressor cells, and adds the last two rows with a logarithmic-depth parallel-prefix adder. It has no clock and no state. A product is valid as soon as the logic settles after the operands change, so the enclosing datapath decides where to place registers around it.

The reduction works on whole rows. One layer of 5:2 compressor cells folds five rows into a sum row and a carry row. Beside it, a layer of 4:2 cells folds the remaining three rows, with one row tied to zero, into two rows. A second layer of 4:2 cells then folds the resulting four rows into two. Inside each layer, the lateral carries of every cell feed the carry inputs of the cell one column to the left. The lateral carry-out of each cell is computed without using its own carry-in, so these carries never ripple along the row. The final carry-propagate addition is a Sklansky prefix tree over the two remaining rows.

Top module: `cmpw_mul`

## Requirements
- R1: For every pair of 8-bit unsigned operands, `product` equals op_a × op_b as a 16-bit unsigned value.
- R2: When either operand is zero, `product` is zero.
- R3: When one operand is 1, `product` equals the other operand, zero-extended to 16 bits.
- R4: `product` never exceeds 65025, and operands 255 and 255 give 16'hFE01.
- R5: A 4:2 compressor cell with inputs x[3:0] and cin satisfies x[0]+x[1]+x[2]+x[3]+cin = sum + 2·(carry + cout) for all 32 input combinations.
- R6: The lateral carry-out of a 4:2 cell is the same for cin = 0 and cin = 1 under every x[3:0].
- R7: A 5:2 compressor cell with inputs x[4:0] and two carry-ins satisfies x[0]+…+x[4]+cin[0]+cin[1] = sum + 2·(carry + cout[0] + cout[1]) for all 128 input combinations.
- R8: Both lateral carry-outs of a 5:2 cell are the same for all four values of cin[1:0] under every x[4:0].
- R9: The product does not depend on operand order: op_a × op_b gives the same `product` as op_b × op_a.
- R10: When op_b is 2^k for k in 0..7, `product` equals op_a shifted left by k bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | 8 | Multiplicand, unsigned |
| op_b | input | 8 | Multiplier, unsigned; bit i selects partial-product row i |
| product | output | 16 | Unsigned product, combinational |

## Verification
A cell often produces a lateral carry-out and receives a lateral carry-in from its right-hand neighbour in the same evaluation. The inner columns of the 5:2 layer can even hold both carry pairs at once. Operands with long runs of ones, with 255 × 255 as the extreme case, fill every column and make both effects occur together, and the full sweep of operand pairs reaches all of these overlaps. Each result is judged against an integer multiply computed in the bench. The cells are also swept alone, which separates an arithmetic error inside a cell from a wiring error between columns.

// File: rtl/cmpw_pkg.sv
package cmpw_pkg;
  // Default operand width; the row schedule in the top is laid out for eight rows.
  localparam int unsigned OPW_DEF = 8;

  function automatic logic maj3(input logic a, input logic b, input logic c);
    return (a & b) | (a & c) | (b & c);
  endfunction
endpackage

// File: rtl/cmpw_ppgen.sv
module cmpw_ppgen #(
  parameter int unsigned WIDTH = 8,
  localparam int unsigned PW = 2 * WIDTH
) (
  input  logic [WIDTH-1:0]         op_a,
  input  logic [WIDTH-1:0]         op_b,
  output logic [WIDTH-1:0][PW-1:0] rows
);
  // Row r is the multiplicand gated by multiplier bit r, placed at weight 2^r.
  for (genvar r = 0; r < WIDTH; r++) begin : g_row
    assign rows[r] = PW'({WIDTH{op_b[r]}} & op_a) << r;
  end
endmodule

// File: rtl/cmpw_c42.sv
module cmpw_c42
  import cmpw_pkg::*;
(
  input  logic [3:0] x,
  input  logic       cin,
  output logic       sum_o,
  output logic       carry_o,
  output logic       cout_o
);
  logic x01, x23, mid;

  // Balanced XOR pairs: sum is three XOR levels deep.
  assign x01     = x[0] ^ x[1];
  assign x23     = x[2] ^ x[3];
  assign mid     = x01 ^ x23;
  assign cout_o  = maj3(x[0], x[1], x[2]);   // no dependence on cin
  assign sum_o   = mid ^ cin;
  assign carry_o = mid ? cin : x[3];
endmodule

// File: rtl/cmpw_c52.sv
module cmpw_c52
  import cmpw_pkg::*;
(
  input  logic [4:0] x,
  input  logic [1:0] cin,
  output logic       sum_o,
  output logic       carry_o,
  output logic [1:0] cout_o
);
  logic t1, t2;

  assign t1        = x[0] ^ x[1] ^ x[2];
  assign cout_o[0] = maj3(x[0], x[1], x[2]);
  assign t2        = t1 ^ x[3] ^ x[4];
  assign cout_o[1] = maj3(t1, x[3], x[4]);
  assign sum_o     = t2 ^ cin[0] ^ cin[1];
  assign carry_o   = maj3(t2, cin[0], cin[1]);
endmodule

// File: rtl/cmpw_row42.sv
module cmpw_row42 #(
  parameter int unsigned PW = 16
) (
  input  logic [3:0][PW-1:0] rin,
  output logic [PW-1:0]      s_row,
  output logic [PW-1:0]      c_row
);
  logic [PW-2:0] cy;
  logic [PW-2:0] co;
  logic [PW-1:0] ci;

  assign ci    = {co, 1'b0};
  assign c_row = {cy, 1'b0};

  for (genvar j = 0; j < PW; j++) begin : g_col
    if (j < PW - 1) begin : g_cell
      cmpw_c42 u_c (
        .x      ({rin[3][j], rin[2][j], rin[1][j], rin[0][j]}),
        .cin    (ci[j]),
        .sum_o  (s_row[j]),
        .carry_o(cy[j]),
        .cout_o (co[j])
      );
    end else begin : g_msb
      // Carries out of the top column fall outside the product width.
      assign s_row[j] = rin[3][j] ^ rin[2][j] ^ rin[1][j] ^ rin[0][j] ^ ci[j];
    end
  end
endmodule

// File: rtl/cmpw_row52.sv
module cmpw_row52 #(
  parameter int unsigned PW = 16
) (
  input  logic [4:0][PW-1:0] rin,
  output logic [PW-1:0]      s_row,
  output logic [PW-1:0]      c_row
);
  logic [PW-2:0] cy;
  logic [PW-2:0] co0, co1;
  logic [PW-1:0] ci0, ci1;

  assign ci0   = {co0, 1'b0};
  assign ci1   = {co1, 1'b0};
  assign c_row = {cy, 1'b0};

  for (genvar j = 0; j < PW; j++) begin : g_col
    if (j < PW - 1) begin : g_cell
      cmpw_c52 u_c (
        .x      ({rin[4][j], rin[3][j], rin[2][j], rin[1][j], rin[0][j]}),
        .cin    ({ci1[j], ci0[j]}),
        .sum_o  (s_row[j]),
        .carry_o(cy[j]),
        .cout_o ({co1[j], co0[j]})
      );
    end else begin : g_msb
      assign s_row[j] = rin[4][j] ^ rin[3][j] ^ rin[2][j] ^ rin[1][j] ^ rin[0][j]
                        ^ ci0[j] ^ ci1[j];
    end
  end
endmodule

// File: rtl/cmpw_sklansky.sv
module cmpw_sklansky #(
  parameter int unsigned PW = 16,
  localparam int unsigned NODES = PW - 1,
  localparam int unsigned LV = $clog2(NODES)
) (
  input  logic [PW-1:0] xa,
  input  logic [PW-1:0] xb,
  output logic [PW-1:0] sum
);
  always_comb begin
    logic [NODES-1:0] gv;
    logic [NODES-1:0] pv;
    int src;
    gv = xa[NODES-1:0] & xb[NODES-1:0];
    pv = xa[NODES-1:0] ^ xb[NODES-1:0];
    src = 0;
    // Level k: a node whose index has bit k set takes the last node of the
    // 2^k block just below it. That node has bit k clear, so it does not
    // change in this level and the update can be done in place.
    for (int k = 0; k < LV; k++) begin
      for (int i = 0; i < NODES; i++) begin
        if (i[k]) begin
          src   = ((i >> k) << k) - 1;
          gv[i] = gv[i] | (pv[i] & gv[src]);
          pv[i] = pv[i] & pv[src];
        end
      end
    end
    sum[0] = xa[0] ^ xb[0];
    for (int i = 1; i < PW; i++) begin
      sum[i] = xa[i] ^ xb[i] ^ gv[i-1];
    end
  end
endmodule

// File: rtl/cmpw_mul.sv
module cmpw_mul
  import cmpw_pkg::*;
#(
  parameter int unsigned WIDTH = OPW_DEF
) (
  input  logic [WIDTH-1:0]   op_a,
  input  logic [WIDTH-1:0]   op_b,
  output logic [2*WIDTH-1:0] product
);
  localparam int unsigned PW = 2 * WIDTH;

  logic [WIDTH-1:0][PW-1:0] pp;
  logic [PW-1:0] s5, c5, s3, c3, sf, cf;

  cmpw_ppgen #(.WIDTH(WIDTH)) u_pp (
    .op_a(op_a),
    .op_b(op_b),
    .rows(pp)
  );

  // Layer 1a: rows 0..4 through 5:2 cells.
  cmpw_row52 #(.PW(PW)) u_l1_wide (
    .rin  ({pp[4], pp[3], pp[2], pp[1], pp[0]}),
    .s_row(s5),
    .c_row(c5)
  );

  // Layer 1b: rows 5..7 plus a zero row through 4:2 cells.
  cmpw_row42 #(.PW(PW)) u_l1_narrow (
    .rin  ({{PW{1'b0}}, pp[7], pp[6], pp[5]}),
    .s_row(s3),
    .c_row(c3)
  );

  // Layer 2: the four carry-save rows down to two.
  cmpw_row42 #(.PW(PW)) u_l2 (
    .rin  ({c3, s3, c5, s5}),
    .s_row(sf),
    .c_row(cf)
  );

  cmpw_sklansky #(.PW(PW)) u_cpa (
    .xa (sf),
    .xb (cf),
    .sum(product)
  );
endmodule

// File: rtl/cmpw_mul_chk.sv
module cmpw_mul_chk #(
  parameter int unsigned WIDTH = 8
) (
  input logic [WIDTH-1:0]   op_a,
  input logic [WIDTH-1:0]   op_b,
  input logic [2*WIDTH-1:0] product
);
  localparam int unsigned PW = 2 * WIDTH;
  localparam logic [PW-1:0] PMAX = PW'(((2 ** WIDTH) - 1) * ((2 ** WIDTH) - 1));

  logic [PW-1:0] want;

  always_comb begin
    want = PW'(op_a) * PW'(op_b);
    p_exact_r1: assert (product == want);
    if (op_a == '0 || op_b == '0) begin
      p_zero_r2: assert (product == '0);
    end
    if (op_b == WIDTH'(1)) begin
      p_unit_b_r3: assert (product == PW'(op_a));
    end
    if (op_a == WIDTH'(1)) begin
      p_unit_a_r3: assert (product == PW'(op_b));
    end
    p_bound_r4: assert (product <= PMAX);
    for (int k = 0; k < WIDTH; k++) begin
      if (op_b == WIDTH'(1) << k) begin
        p_shift_r10: assert (product == (PW'(op_a) << k));
      end
    end
  end
endmodule

module cmpw_c42_chk (
  input logic [3:0] x,
  input logic       cin,
  input logic       sum_o,
  input logic       carry_o,
  input logic       cout_o
);
  always_comb begin
    p_cell42_r5: assert ((3'(x[0]) + 3'(x[1]) + 3'(x[2]) + 3'(x[3]) + 3'(cin))
                         == (3'(sum_o) + 3'(2) * (3'(carry_o) + 3'(cout_o))));
  end
endmodule

module cmpw_c52_chk (
  input logic [4:0] x,
  input logic [1:0] cin,
  input logic       sum_o,
  input logic       carry_o,
  input logic [1:0] cout_o
);
  always_comb begin
    p_cell52_r7: assert ((3'(x[0]) + 3'(x[1]) + 3'(x[2]) + 3'(x[3]) + 3'(x[4])
                          + 3'(cin[0]) + 3'(cin[1]))
                         == (3'(sum_o) + 3'(2) * (3'(carry_o) + 3'(cout_o[0]) + 3'(cout_o[1]))));
  end
endmodule

bind cmpw_mul cmpw_mul_chk #(.WIDTH(WIDTH)) u_mul_chk (.*);
bind cmpw_c42 cmpw_c42_chk u_c42_chk (.*);
bind cmpw_c52 cmpw_c52_chk u_c52_chk (.*);

// File: tb/cmpw_mul_tb.sv
`timescale 1ns/1ps
module cmpw_mul_tb;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;   // 200 MHz

  logic       rst_n;
  logic [7:0] a, b;
  logic [15:0] prod;

  logic [3:0] x4;
  logic       ci4, s4, cy4, co4;
  logic [4:0] x5;
  logic [1:0] ci5, co5;
  logic       s5, cy5;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  cmpw_mul u_dut (.op_a(a), .op_b(b), .product(prod));
  cmpw_c42 u_c42 (.x(x4), .cin(ci4), .sum_o(s4), .carry_o(cy4), .cout_o(co4));
  cmpw_c52 u_c52 (.x(x5), .cin(ci5), .sum_o(s5), .carry_o(cy5), .cout_o(co5));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic apply(input int va, input int vb);
    @(posedge clk);
    a = 8'(va);
    b = 8'(vb);
    @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic saved;
    logic [1:0] saved2;
    logic [15:0] fwd;
    rst_n = 1'b0;
    a = '0; b = '0; x4 = '0; ci4 = 1'b0; x5 = '0; ci5 = '0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R2 idle operands", 32'(prod), 32'd0);

    // R5: 4:2 cell identity over all inputs.
    for (int v = 0; v < 32; v++) begin
      @(posedge clk); x4 = 4'(v >> 1); ci4 = v[0];
      @(negedge clk);
      chk("R5 c42 identity", 32'(s4) + 2 * (32'(cy4) + 32'(co4)), 32'($countones(5'(v))));
    end
    // R6: 4:2 lateral carry-out ignores cin.
    for (int v = 0; v < 16; v++) begin
      @(posedge clk); x4 = 4'(v); ci4 = 1'b0;
      @(negedge clk); saved = co4;
      @(posedge clk); ci4 = 1'b1;
      @(negedge clk);
      chk("R6 c42 cout vs cin", 32'(co4), 32'(saved));
    end
    // R7: 5:2 cell identity over all inputs.
    for (int v = 0; v < 128; v++) begin
      @(posedge clk); x5 = 5'(v >> 2); ci5 = 2'(v);
      @(negedge clk);
      chk("R7 c52 identity", 32'(s5) + 2 * (32'(cy5) + 32'(co5[0]) + 32'(co5[1])),
          32'($countones(7'(v))));
    end
    // R8: 5:2 lateral carry-outs ignore both carry-ins.
    for (int v = 0; v < 32; v++) begin
      @(posedge clk); x5 = 5'(v); ci5 = 2'd0;
      @(negedge clk); saved2 = co5;
      for (int c = 1; c < 4; c++) begin
        @(posedge clk); ci5 = 2'(c);
        @(negedge clk);
        chk("R8 c52 couts vs cin", 32'(co5), 32'(saved2));
      end
    end

    // R4 corner: all ones.
    apply(255, 255);
    chk("R4 max product", 32'(prod), 32'h0000FE01);

    // R1 exhaustive sweep with derived checks.
    for (int ia = 0; ia < 256; ia++) begin
      for (int ib = 0; ib < 256; ib++) begin
        apply(ia, ib);
        chk("R1 product", 32'(prod), 32'(ia * ib));
        if (ia == 0 || ib == 0) chk("R2 zero operand", 32'(prod), 32'd0);
        if (ib == 1) chk("R3 op_b one", 32'(prod), 32'(ia));
        if (ia == 1) chk("R3 op_a one", 32'(prod), 32'(ib));
        chk("R4 bound", 32'(prod <= 16'd65025), 32'd1);
        for (int k = 0; k < 8; k++) begin
          if (ib == (1 << k)) chk("R10 power of two", 32'(prod), 32'(ia << k));
        end
      end
    end

    // R9: swap operands on a spread of pairs.
    for (int n = 0; n < 64; n++) begin
      int pa, pb;
      pa = (37 * n + 3) % 256;
      pb = (101 * n + 250) % 256;
      apply(pa, pb); fwd = prod;
      apply(pb, pa);
      chk("R9 operand swap", 32'(prod), 32'(fwd));
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule